// File: doc/BRIEF.md
# PCI Initiator Address Phase Controller

This block opens a transaction on a shared PCI bus on behalf of a local requester. The requester hands over a target address, a bus command, byte enables, a read flag and a 64-bit flag through a valid/ready port. The block then waits until it holds the grant and the bus is idle. It drives the address and command for the address phase, using two address cycles when a 64-bit address is really needed, and asserts FRAME#.

While the address phase runs, the block watches DEVSEL#. If a target claims the cycle inside the allowed window, the block reports a claim. If no target answers before the window closes, it ends the cycle with a master abort, reports the abort, and returns all-ones data for a read.

Back-pressure rules: `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The block then deasserts `req_ready` until the cycle after its `done` pulse, so the requester may change or drop its fields as soon as the request has been taken. The outcome pins `done`, `aborted` and `rd_data` are plain status and carry no handshake.

Cycle numbering used below: cycle 1 is the first clock cycle in which `frame_n_o` is low. DEVSEL# is "seen at the end of cycle k" when `devsel_n` is low at the rising edge that closes cycle k.

Top module: `pci_addr_initiator`

## Requirements
- R1: `req_ready` is 1 only in the idle state. A request is accepted on an edge with `req_valid` and `req_ready` both high, and `req_ready` stays 0 from the accept until the cycle after `done`.
- R2: After an accept, cycle 1 begins one cycle after the first rising edge at which `gnt_n`=0, `frame_in_n`=1 and `irdy_in_n`=1 are all sampled (this edge is at the earliest one cycle after the accept). While the bus is not free, `frame_n_o` stays 1.
- R3: In a single-cycle address phase, cycle 1 drives `ad_o`=addr[31:0] with `ad_oe`=1 and `cbe_o`=command. From cycle 2 until `done`, `ad_oe`=0, `cbe_o` carries the byte enables, and `irdy_n_o`=0.
- R4: A dual-cycle address phase drives addr[31:0] with `cbe_o`=4'b1101 in cycle 1 and addr[63:32] with the real command in cycle 2. From cycle 3 until `done`, the AD lines are released, the byte enables are driven and `irdy_n_o`=0.
- R5: The dual-cycle form is used only when `req_wide`=1 and addr[63:32] is nonzero. A wide request whose upper half is zero gets a single-cycle address phase.
- R6: In single mode, DEVSEL# seen at the end of any of cycles 1 to 4 claims the transaction. In dual mode the window is cycles 2 to 5, and DEVSEL# at the end of cycle 1 is ignored. After a claim, `done` is high in the next cycle with `aborted`=0.
- R7: If DEVSEL# is not seen by the end of cycle 4 (single) or cycle 5 (dual), `frame_n_o` returns to 1 in cycle 5 (single) or cycle 6 (dual), and that cycle carries `done`=1 with `aborted`=1.
- R8: `done` lasts exactly one cycle. During it `frame_n_o`=1 and `irdy_n_o`=0. In the next cycle, `irdy_n_o`=1, `ad_oe`=0 and `cbe_oe`=0.
- R9: `rd_data` is 32'hFFFFFFFF while `done` is high for an aborted read. In every other cycle `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 64 | Target address |
| req_cmd | input | 4 | Bus command code |
| req_be | input | 4 | Active-low byte enables for the first data phase |
| req_read | input | 1 | Request is a read |
| req_wide | input | 1 | Requester asks for 64-bit addressing |
| gnt_n | input | 1 | Bus grant, active low |
| frame_in_n | input | 1 | Sampled FRAME# of the bus |
| irdy_in_n | input | 1 | Sampled IRDY# of the bus |
| devsel_n | input | 1 | Target claim, active low |
| ad_o | output | 32 | Address value for the AD lines |
| ad_oe | output | 1 | AD output enable |
| cbe_o | output | 4 | Command or byte enable value |
| cbe_oe | output | 1 | C/BE output enable |
| frame_n_o | output | 1 | Driven FRAME# |
| irdy_n_o | output | 1 | Driven IRDY# |
| done | output | 1 | One-cycle outcome pulse |
| aborted | output | 1 | Outcome was a master abort (valid with done) |
| rd_data | output | 32 | All-ones on an aborted read, else zero |

## Verification
On every cycle, the embedded properties check several rules. FRAME# may fall only after a free-bus sample. The AD lines must be released right after a single address cycle. The dual-address code may appear only with a nonzero upper half. An abort requires DEVSEL# to have been high at the deciding edge. The outcome pulse must last a single cycle. The cycle-cost of each decision needs the bench's scenarios, because only they can show it: where a late claim (cycle 4, or cycle 5 in dual mode) still counts, where the abort lands, how the DEVSEL# window shifts in dual mode, and that the byte enables and read data carry the right values.

// File: rtl/pci_ap_pkg.sv
package pci_ap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADR1,
    ST_ADR2,
    ST_WAIT,
    ST_END
  } ap_state_e;

  localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;
endpackage

// File: rtl/pci_ap_req_reg.sv
module pci_ap_req_reg #(
  parameter int AD_W = 32,
  parameter int CB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2*AD_W-1:0] addr,
  input  logic [CB_W-1:0]   cmd,
  input  logic [CB_W-1:0]   be,
  input  logic              rd,
  input  logic              wide,
  output logic [AD_W-1:0]   lo_q,
  output logic [AD_W-1:0]   hi_q,
  output logic [CB_W-1:0]   cmd_q,
  output logic [CB_W-1:0]   be_q,
  output logic              rd_q,
  output logic              dual_q
);
  // A wide request only needs two address cycles if its upper half is nonzero
  logic dual_d;
  assign dual_d = wide && (addr[2*AD_W-1:AD_W] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      cmd_q  <= '0;
      be_q   <= '1;
      rd_q   <= 1'b0;
      dual_q <= 1'b0;
    end else if (load) begin
      lo_q   <= addr[AD_W-1:0];
      hi_q   <= addr[2*AD_W-1:AD_W];
      cmd_q  <= cmd;
      be_q   <= be;
      rd_q   <= rd;
      dual_q <= dual_d;
    end
  end
endmodule

// File: rtl/pci_ap_devsel_timer.sv
module pci_ap_devsel_timer #(
  parameter int SINGLE_LAST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic dual,
  output logic last
);
  localparam int CW = $clog2(SINGLE_LAST + 3);
  localparam logic [CW-1:0] LIM_S = CW'(SINGLE_LAST);
  localparam logic [CW-1:0] LIM_D = CW'(SINGLE_LAST + 1);

  logic [CW-1:0] cyc;

  // cyc holds the number of the current cycle, counted from the first FRAME# low cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cyc <= '0;
    else if (start) cyc <= CW'(1);
    else if (run)   cyc <= cyc + CW'(1);
    else            cyc <= '0;
  end

  assign last = run && (cyc == (dual ? LIM_D : LIM_S));

  // R7: the counter never runs past the end of the longer window
  p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cyc <= LIM_D));
endmodule

// File: rtl/pci_ap_bus_drive.sv
module pci_ap_bus_drive
  import pci_ap_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int CB_W = 4
) (
  input  ap_state_e        st,
  input  logic             dual,
  input  logic [AD_W-1:0]  lo,
  input  logic [AD_W-1:0]  hi,
  input  logic [CB_W-1:0]  cmd,
  input  logic [CB_W-1:0]  be,
  output logic [AD_W-1:0]  ad_o,
  output logic             ad_oe,
  output logic [CB_W-1:0]  cbe_o,
  output logic             cbe_oe,
  output logic             frame_n_o,
  output logic             irdy_n_o
);
  always_comb begin
    ad_o      = '0;
    ad_oe     = 1'b0;
    cbe_o     = '0;
    cbe_oe    = 1'b0;
    frame_n_o = 1'b1;
    irdy_n_o  = 1'b1;
    unique case (st)
      ST_ADR1: begin
        ad_o      = lo;
        ad_oe     = 1'b1;
        cbe_o     = dual ? CB_W'(CMD_DUAL_ADDR) : cmd;
        cbe_oe    = 1'b1;
        frame_n_o = 1'b0;
      end
      ST_ADR2: begin
        ad_o      = hi;
        ad_oe     = 1'b1;
        cbe_o     = cmd;
        cbe_oe    = 1'b1;
        frame_n_o = 1'b0;
      end
      ST_WAIT: begin
        cbe_o     = be;
        cbe_oe    = 1'b1;
        frame_n_o = 1'b0;
        irdy_n_o  = 1'b0;
      end
      ST_END: begin
        cbe_o     = be;
        cbe_oe    = 1'b1;
        irdy_n_o  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_addr_initiator.sv
module pci_addr_initiator
  import pci_ap_pkg::*;
#(
  parameter int AD_W        = 32,
  parameter int CB_W        = 4,
  parameter int SINGLE_LAST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2*AD_W-1:0] req_addr,
  input  logic [CB_W-1:0]   req_cmd,
  input  logic [CB_W-1:0]   req_be,
  input  logic              req_read,
  input  logic              req_wide,
  input  logic              gnt_n,
  input  logic              frame_in_n,
  input  logic              irdy_in_n,
  input  logic              devsel_n,
  output logic [AD_W-1:0]   ad_o,
  output logic              ad_oe,
  output logic [CB_W-1:0]   cbe_o,
  output logic              cbe_oe,
  output logic              frame_n_o,
  output logic              irdy_n_o,
  output logic              done,
  output logic              aborted,
  output logic [AD_W-1:0]   rd_data
);
  ap_state_e st, st_nx;
  logic [AD_W-1:0] lo_q, hi_q;
  logic [CB_W-1:0] cmd_q, be_q;
  logic rd_q, dual_q, abort_q, abort_d;
  logic accept, bus_free, claim_ok, claim, last, t_start, t_run;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bus_free  = !gnt_n && frame_in_n && irdy_in_n;
  // In dual mode the first address cycle cannot be claimed: the window slides by one
  assign claim_ok  = (st == ST_ADR1 && !dual_q) || (st == ST_ADR2) || (st == ST_WAIT);
  assign claim     = claim_ok && !devsel_n;
  assign t_start   = (st == ST_ARB) && bus_free;
  assign t_run     = (st == ST_ADR1) || (st == ST_ADR2) || (st == ST_WAIT);

  pci_ap_req_reg #(.AD_W(AD_W), .CB_W(CB_W)) u_req (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .addr(req_addr), .cmd(req_cmd), .be(req_be), .rd(req_read), .wide(req_wide),
    .lo_q(lo_q), .hi_q(hi_q), .cmd_q(cmd_q), .be_q(be_q), .rd_q(rd_q), .dual_q(dual_q)
  );

  pci_ap_devsel_timer #(.SINGLE_LAST(SINGLE_LAST)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(t_start), .run(t_run), .dual(dual_q), .last(last)
  );

  pci_ap_bus_drive #(.AD_W(AD_W), .CB_W(CB_W)) u_drv (
    .st(st), .dual(dual_q), .lo(lo_q), .hi(hi_q), .cmd(cmd_q), .be(be_q),
    .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
    .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o)
  );

  always_comb begin
    st_nx   = st;
    abort_d = abort_q;
    unique case (st)
      ST_IDLE: if (accept) st_nx = ST_ARB;
      ST_ARB:  if (bus_free) st_nx = ST_ADR1;
      ST_ADR1: begin
        if (claim) begin
          st_nx = ST_END; abort_d = 1'b0;
        end else if (dual_q) begin
          st_nx = ST_ADR2;
        end else if (last) begin
          st_nx = ST_END; abort_d = 1'b1;
        end else begin
          st_nx = ST_WAIT;
        end
      end
      ST_ADR2: begin
        if (claim) begin
          st_nx = ST_END; abort_d = 1'b0;
        end else if (last) begin
          st_nx = ST_END; abort_d = 1'b1;
        end else begin
          st_nx = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (claim) begin
          st_nx = ST_END; abort_d = 1'b0;
        end else if (last) begin
          st_nx = ST_END; abort_d = 1'b1;
        end
      end
      ST_END:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st      <= st_nx;
      abort_q <= abort_d;
    end
  end

  assign done    = (st == ST_END);
  assign aborted = done && abort_q;
  assign rd_data = (done && abort_q && rd_q) ? '1 : '0;

  // R2: FRAME# falls only after an edge that saw grant and an idle bus
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n_o) |-> $past(!gnt_n && frame_in_n && irdy_in_n));

  // R1: while ready, nothing is driven on the bus
  p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (frame_n_o && !ad_oe));

  // R3: a single address cycle releases AD on the next cycle
  p_ad_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && !frame_n_o && !dual_q && st == ST_ADR1) |=> !ad_oe);

  // R5: the dual-address code never goes out with a zero upper half
  p_dual_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADR1 && cbe_o == CB_W'(CMD_DUAL_ADDR) && cmd_q != CB_W'(CMD_DUAL_ADDR))
      |-> (hi_q != '0));

  // R7: an abort means DEVSEL# was high at the deciding edge
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> $past(devsel_n));

  // R8: the outcome pulse lasts one cycle, with FRAME# high
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (frame_n_o ##1 !done));
endmodule

// File: tb/pci_addr_initiator_test.sv
module pci_addr_initiator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [3:0]  req_cmd = '0;
  logic [3:0]  req_be = '0;
  logic        req_read = 1'b0;
  logic        req_wide = 1'b0;
  logic        gnt_n = 1'b1;
  logic        frame_in_n = 1'b1;
  logic        irdy_in_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic [31:0] ad_o;
  logic        ad_oe;
  logic [3:0]  cbe_o;
  logic        cbe_oe;
  logic        frame_n_o;
  logic        irdy_n_o;
  logic        done;
  logic        aborted;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  int cyc_count = 0;

  always #10 clk = ~clk;

  pci_addr_initiator uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_read(req_read),
    .req_wide(req_wide), .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n),
    .devsel_n(devsel_n), .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe),
    .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o), .done(done), .aborted(aborted),
    .rd_data(rd_data)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_dual(input logic wide, input logic [63:0] a);
    return wide && (a[63:32] != 32'h0);
  endfunction

  // blk: 0 grant withheld, 1 FRAME# busy, 2 IRDY# busy (for `hold` cycles)
  task automatic run_txn(input logic wide, input logic [63:0] a, input logic [3:0] cmd,
                         input logic [3:0] be, input logic rd, input int claim_at,
                         input int hold, input int blk);
    bit dual;
    int first, limit, eff, end_c, dstart;
    bit claimed;
    dual    = is_dual(wide, a);
    first   = dual ? 2 : 1;
    limit   = dual ? 5 : 4;
    eff     = (claim_at < first) ? first : claim_at;
    claimed = (eff <= limit);
    end_c   = claimed ? eff + 1 : limit + 1;
    dstart  = dual ? 3 : 2;

    req_addr = a; req_cmd = cmd; req_be = be; req_read = rd; req_wide = wide;
    req_valid = 1'b1;
    gnt_n      = (hold > 0 && blk == 0);
    frame_in_n = !(hold > 0 && blk == 1);
    irdy_in_n  = !(hold > 0 && blk == 2);
    chk(req_ready == 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = '0; req_cmd = '0; req_be = '0; req_read = 1'b0; req_wide = 1'b0;
    chk(req_ready == 1'b0, "R1 ready dropped after accept", 64'(req_ready), 64'd0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(frame_n_o == 1'b1, "R2 no start while bus not free", 64'(frame_n_o), 64'd1);
    end
    gnt_n = 1'b0; frame_in_n = 1'b1; irdy_in_n = 1'b1;
    @(negedge clk);
    for (int c = 1; c <= end_c; c++) begin
      if (c == 1) begin
        chk(frame_n_o == 1'b0, "R2 FRAME# low in cycle 1", 64'(frame_n_o), 64'd0);
        chk(ad_oe && ad_o == a[31:0], "R3 R4 low address in cycle 1", 64'(ad_o), 64'(a[31:0]));
        chk(cbe_o == (dual ? 4'b1101 : cmd), "R4 R5 command code in cycle 1",
            64'(cbe_o), 64'(dual ? 4'b1101 : cmd));
      end
      if (c == 2 && dual) begin
        chk(ad_oe && ad_o == a[63:32] && cbe_o == cmd, "R4 high address and command",
            {ad_o, 28'h0, cbe_o}, {a[63:32], 28'h0, cmd});
      end
      if (c >= dstart && c < end_c) begin
        chk(!ad_oe && cbe_o == be && !irdy_n_o && !frame_n_o, "R3 R4 data-phase drive",
            {58'h0, ad_oe, irdy_n_o, cbe_o}, {58'h0, 2'b00, be});
      end
      if (c < end_c) begin
        chk(done == 1'b0, "R6 R7 no early outcome", 64'(done), 64'd0);
      end else begin
        chk(done && frame_n_o && !irdy_n_o, "R8 outcome cycle pins",
            {61'h0, done, frame_n_o, irdy_n_o}, 64'b110);
        chk(aborted == !claimed, claimed ? "R6 claim status" : "R7 abort status",
            64'(aborted), 64'(!claimed));
        chk(rd_data == ((!claimed && rd) ? 32'hFFFF_FFFF : 32'h0), "R9 read data",
            64'(rd_data), 64'((!claimed && rd) ? 32'hFFFF_FFFF : 32'h0));
      end
      devsel_n = (c >= claim_at) ? 1'b0 : 1'b1;
      if (c == end_c) devsel_n = 1'b1;
      @(negedge clk);
    end
    chk(!done && irdy_n_o && !ad_oe && !cbe_oe && req_ready, "R8 release after outcome",
        {59'h0, done, irdy_n_o, ad_oe, cbe_oe, req_ready}, 64'b01001);
    chk(rd_data == 32'h0, "R9 read data zero when idle", 64'(rd_data), 64'd0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc_count++;
      if (cyc_count > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc_count);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && frame_n_o == 1'b1 && done == 1'b0, "R1 reset state",
        {61'h0, req_ready, frame_n_o, done}, 64'b110);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners: single claim edges, abort, dual window edges, wide with zero upper
    run_txn(1'b0, 64'h0000_0000_1000_0040, 4'h6, 4'h0, 1'b1, 1, 0, 0);  // R6 fastest
    run_txn(1'b0, 64'h0000_0000_2000_0000, 4'h7, 4'h3, 1'b0, 4, 0, 0);  // R6 last
    run_txn(1'b0, 64'h0000_0000_3000_0010, 4'h6, 4'h0, 1'b1, 9, 0, 0);  // R7 R9 abort read
    run_txn(1'b0, 64'h0000_0000_3000_0020, 4'h7, 4'h0, 1'b0, 5, 0, 0);  // R7 claim too late
    run_txn(1'b1, 64'h0000_0001_4000_0000, 4'h6, 4'h1, 1'b1, 1, 0, 0);  // R4 R6 ignored at 1
    run_txn(1'b1, 64'h0000_0002_4000_0000, 4'h6, 4'h1, 1'b1, 5, 0, 0);  // R6 dual last
    run_txn(1'b1, 64'hABCD_0000_5000_0000, 4'hC, 4'h0, 1'b1, 9, 0, 0);  // R7 dual abort
    run_txn(1'b1, 64'h0000_0000_6000_0000, 4'h6, 4'h0, 1'b1, 9, 0, 0);  // R5 single
    run_txn(1'b0, 64'h0000_0000_7000_0000, 4'h3, 4'h5, 1'b0, 2, 3, 0);  // R2 grant late
    run_txn(1'b0, 64'h0000_0000_7100_0000, 4'h2, 4'h5, 1'b1, 3, 2, 1);  // R2 frame busy
    run_txn(1'b1, 64'h0000_0F00_7200_0000, 4'h6, 4'h5, 1'b1, 3, 2, 2);  // R2 irdy busy

    for (int n = 0; n < 60; n++) begin
      logic [63:0] a;
      a[31:0]  = $urandom;
      a[63:32] = ($urandom % 3 == 0) ? 32'h0 : $urandom;
      run_txn(1'($urandom % 2), a, 4'($urandom), 4'($urandom), 1'($urandom % 2),
              1 + int'($urandom % 7), int'($urandom % 3), int'($urandom % 3));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule